// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Front-End

This block is the bus-facing half of a serial byte memory of 8K x 8. It watches a two-wire bus (clock and data lines, both sampled by the core clock), picks out start and stop conditions, and answers to one device address. Three strap pins set part of that address. It pulls the data line low through an output-enable to acknowledge bytes and to send read data. It never drives the line high.

The host opens a write with the device byte, then sends two word-address bytes, then any number of data bytes. Each data byte leaves the block as a one-cycle strobe that carries its memory address. A stop that follows at least one data byte sends a commit pulse to the page-write engine. While that engine raises its busy input, the block refuses to acknowledge its own device address, so the host can poll for the end of the write cycle. A read opened with the device byte returns the byte at the internal address pointer, which is a current-address read.

The address pointer steps only through the low page bits while data is written, so it stays inside one page. A read steps the whole pointer.

Top module: `i2c_ee_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START. From any state it restarts reception of a device byte at bit 0 with the data line released. A rising data line while the clock line is high is a STOP, and it returns the block to idle.
- R2: The device byte is sent MSB first. It is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal `strap_i[2:0]`, with bit 3 compared against `strap_i[2]`.
- R3: After a device byte that does not match, the block gives no acknowledge and no write strobe for any further bytes until the next START.
- R4: Bit 0 of the device byte selects the direction: 0 opens a write and 1 opens a read.
- R5: After a write device byte, two word-address bytes follow and each is acknowledged. The 13-bit address is made of bits 4..0 of the first byte above the whole second byte. Bits 7..5 of the first byte are ignored.
- R6: Every data byte of a write is acknowledged and appears once on `wr_data_o`, with its address on `wr_addr_o`, during a one-cycle `wr_valid_o` pulse.
- R7: After each data byte, only address bits 4..0 increment, and they wrap from 31 to 0. Bits 12..5 hold their value.
- R8: A STOP that follows at least one complete data byte gives a single one-cycle `wr_commit_o` pulse. A STOP that follows only address bytes gives no pulse.
- R9: While `wr_busy_i` is high at the end of the device byte, the block does not acknowledge it. Once `wr_busy_i` is low, it acknowledges again.
- R10: On a read, the block shifts out `rd_data_i` MSB first, taken at `rd_addr_o` (the pointer). It then releases the line for the host's acknowledge bit and increments the full 13-bit pointer, which wraps from 0x1FFF to 0x0000.
- R11: `sda_oe_o` changes only while the clock line is low, and it is 0 whenever the block is idle and after reset.
- R12: A START in the middle of a data byte drops the partial byte. The following STOP gives no commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device address strap pins (tie low when unused) |
| wr_busy_i | input | 1 | Page-write engine is running a write cycle |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 13 | Memory address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse: write transfer closed by STOP |
| rd_addr_o | output | 13 | Current address pointer for reads |
| rd_data_i | input | 8 | Memory byte at `rd_addr_o`, combinational |

## Verification
The hardest cases to reach are a START that lands between two bits of a data byte and a device byte that arrives while the engine is busy. Both need the host model to break the normal byte framing at an exact bit. The bench drives the clock and data lines bit by bit, so it can send only four bits of a byte before a repeated START, and it can keep the busy input high across a full polling attempt and its follow-on bytes. A dummy write that ends right after the address bytes positions the pointer at 0x1FFF, so two reads then show the full-width rollover to 0x0000.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_HACK
   } ee_state_e;

   typedef enum logic [1:0] {
      FLD_DEV,
      FLD_AHI,
      FLD_ALO,
      FLD_DATA
   } ee_field_e;

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] ff_q;

   initial begin
      assert (STAGES >= 1) else $error("i2c_ee_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '1;
            else        ff_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= '1;
            else        ff_q <= {ff_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/i2c_ee_cond.sv
module i2c_ee_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_i;
         sda_p <= sda_i;
      end
   end

   assign start_o = scl_p & scl_i & sda_p & ~sda_i;
   assign stop_o  = scl_p & scl_i & ~sda_p & sda_i;
   assign rise_o  = scl_i & ~scl_p;
   assign fall_o  = ~scl_i & scl_p;

endmodule

// File: rtl/i2c_ee_ptr.sv
module i2c_ee_ptr #(
   parameter int ADDR_W = 13,
   parameter int PAGE_W = 5
) (
   input  logic [ADDR_W-1:0] cur_i,
   output logic [ADDR_W-1:0] page_nx_o,
   output logic [ADDR_W-1:0] lin_nx_o
);

   assign lin_nx_o = cur_i + ADDR_W'(1);

   generate
      if (PAGE_W == 0) begin : g_linear
         assign page_nx_o = lin_nx_o;
      end else begin : g_paged
         assign page_nx_o = {cur_i[ADDR_W-1:PAGE_W], cur_i[PAGE_W-1:0] + PAGE_W'(1)};
      end
   endgenerate

endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
   import i2c_ee_pkg::*;
#(
   parameter int          ADDR_W      = 13,
   parameter int          PAGE_W      = 5,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic [2:0]        strap_i,
   input  logic              wr_busy_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_commit_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i
);

   localparam int HI_W = ADDR_W - 8;

   initial begin
      assert (ADDR_W >= 9 && ADDR_W <= 16) else $error("i2c_ee_slave: ADDR_W out of range 9..16");
      assert (PAGE_W >= 0 && PAGE_W < ADDR_W) else $error("i2c_ee_slave: PAGE_W must be below ADDR_W");
      assert (SYNC_STAGES >= 1) else $error("i2c_ee_slave: SYNC_STAGES must be at least 1");
   end

   logic scl_s, sda_s;
   logic start_p, stop_p, rise_p, fall_p;
   logic [ADDR_W-1:0] ptr_page, ptr_lin;

   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_ee_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_s), .sda_i(sda_s),
      .start_o(start_p), .stop_o(stop_p), .rise_o(rise_p), .fall_o(fall_p)
   );

   ee_state_e         st_q;
   ee_field_e         fld_q;
   logic [2:0]        bit_q;
   logic [7:0]        sh_q;
   logic              full_q, rw_q, oe_q, seen_q;
   logic [HI_W-1:0]   hi_q;
   logic [ADDR_W-1:0] ptr_q, wa_q;
   logic [7:0]        wd_q;
   logic              wv_q, cm_q;
   logic              dev_hit;

   i2c_ee_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
      .cur_i(ptr_q), .page_nx_o(ptr_page), .lin_nx_o(ptr_lin)
   );

   assign dev_hit = (sh_q[7:4] == DEV_CODE) && (sh_q[3:1] == strap_i) && !wr_busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fld_q  <= FLD_DEV;
         bit_q  <= '0;
         sh_q   <= '0;
         full_q <= 1'b0;
         rw_q   <= 1'b0;
         oe_q   <= 1'b0;
         seen_q <= 1'b0;
         hi_q   <= '0;
         ptr_q  <= '0;
         wa_q   <= '0;
         wd_q   <= '0;
         wv_q   <= 1'b0;
         cm_q   <= 1'b0;
      end else begin
         wv_q <= 1'b0;
         cm_q <= 1'b0;
         if (start_p) begin
            st_q   <= ST_RX;
            fld_q  <= FLD_DEV;
            bit_q  <= '0;
            full_q <= 1'b0;
            oe_q   <= 1'b0;
            seen_q <= 1'b0;
         end else if (stop_p) begin
            if (st_q != ST_IDLE && fld_q == FLD_DATA && seen_q) cm_q <= 1'b1;
            st_q   <= ST_IDLE;
            oe_q   <= 1'b0;
            seen_q <= 1'b0;
         end else begin
            case (st_q)
               ST_RX: begin
                  if (rise_p && !full_q) begin
                     sh_q  <= {sh_q[6:0], sda_s};
                     bit_q <= bit_q + 3'd1;
                     if (bit_q == 3'd7) full_q <= 1'b1;
                  end else if (fall_p && full_q) begin
                     full_q <= 1'b0;
                     bit_q  <= '0;
                     case (fld_q)
                        FLD_DEV: begin
                           if (dev_hit) begin
                              oe_q <= 1'b1;
                              rw_q <= sh_q[0];
                              st_q <= ST_ACK;
                           end else begin
                              st_q <= ST_IDLE;
                           end
                        end
                        FLD_AHI: begin
                           hi_q <= sh_q[HI_W-1:0];
                           oe_q <= 1'b1;
                           st_q <= ST_ACK;
                        end
                        FLD_ALO: begin
                           ptr_q <= {hi_q, sh_q};
                           oe_q  <= 1'b1;
                           st_q  <= ST_ACK;
                        end
                        default: begin
                           wv_q   <= 1'b1;
                           wa_q   <= ptr_q;
                           wd_q   <= sh_q;
                           ptr_q  <= ptr_page;
                           seen_q <= 1'b1;
                           oe_q   <= 1'b1;
                           st_q   <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (fall_p) begin
                     if (fld_q == FLD_DEV && rw_q) begin
                        st_q  <= ST_TX;
                        bit_q <= '0;
                        oe_q  <= ~rd_data_i[7];
                     end else begin
                        st_q <= ST_RX;
                        oe_q <= 1'b0;
                        case (fld_q)
                           FLD_DEV: fld_q <= FLD_AHI;
                           FLD_AHI: fld_q <= FLD_ALO;
                           default: fld_q <= FLD_DATA;
                        endcase
                     end
                  end
               end
               ST_TX: begin
                  if (fall_p) begin
                     if (bit_q == 3'd7) begin
                        oe_q <= 1'b0;
                        st_q <= ST_HACK;
                     end else begin
                        bit_q <= bit_q + 3'd1;
                        oe_q  <= ~rd_data_i[3'd6 - bit_q];
                     end
                  end
               end
               ST_HACK: begin
                  if (rise_p) begin
                     ptr_q <= ptr_lin;
                     st_q  <= ST_IDLE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign wr_valid_o  = wv_q;
   assign wr_addr_o   = wa_q;
   assign wr_data_o   = wd_q;
   assign wr_commit_o = cm_q;
   assign rd_addr_o   = ptr_q;

   AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> (st_q == ST_RX && fld_q == FLD_DEV && bit_q == 3'd0 && !oe_q)); // R1

   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RX && fld_q == FLD_DEV && full_q && fall_p && wr_busy_i && !start_p && !stop_p)
      |=> !oe_q); // R9

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !sda_oe_o); // R11

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(oe_q) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_s)); // R11

   AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |-> ($past(stop_p) && !wr_valid_o)); // R8

   generate
      if (PAGE_W > 0) begin : g_page_chk
         AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (fld_q == FLD_DATA && $past(fld_q == FLD_DATA)) |-> $stable(ptr_q[ADDR_W-1:PAGE_W])); // R7
      end
   endgenerate

endmodule

// File: tb/sim_i2c_ee_slave.sv
`timescale 1ns/1ps
module sim_i2c_ee_slave;

   typedef struct {
      logic [12:0] a;
      logic [7:0]  d;
      string       tag;
   } wr_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_h = 1'b1;
   logic        sda_line;
   logic        sda_oe;
   logic [2:0]  strap = 3'b101;
   logic        busy = 1'b0;
   logic        wr_valid, wr_commit;
   logic [12:0] wr_addr, rd_addr;
   logic [7:0]  wr_data, rd_data;

   int n_chk = 0;
   int n_fail = 0;
   int exp_commits = 0;
   int got_commits = 0;
   bit done = 1'b0;
   wr_item_t exp_q[$];

   always #2 clk = ~clk;

   assign sda_line = sda_h & ~sda_oe;

   function automatic logic [7:0] mem_val(input logic [12:0] a);
      return a[7:0] ^ {a[12:8], 3'b101};
   endfunction

   assign rd_data = mem_val(rd_addr);

   i2c_ee_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .strap_i(strap), .wr_busy_i(busy), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
      .wr_data_o(wr_data), .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic h_start();
      scl = 1'b0; w(5);
      sda_h = 1'b1; w(5);
      scl = 1'b1; w(10);
      sda_h = 1'b0; w(10);
      scl = 1'b0; w(5);
   endtask

   task automatic h_stop();
      scl = 1'b0; w(5);
      sda_h = 1'b0; w(5);
      scl = 1'b1; w(10);
      sda_h = 1'b1; w(10);
   endtask

   task automatic h_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_h = b[i]; w(5);
         scl = 1'b1; w(10);
         scl = 1'b0; w(5);
      end
   endtask

   task automatic h_send(input logic [7:0] b, output logic ack);
      h_bits(b, 8);
      sda_h = 1'b1; w(5);
      scl = 1'b1; w(5);
      ack = (sda_line == 1'b0);
      w(5);
      scl = 1'b0; w(5);
   endtask

   task automatic h_recv(output logic [7:0] b);
      sda_h = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         w(5);
         scl = 1'b1; w(5);
         b[i] = sda_line;
         w(5);
         scl = 1'b0;
      end
      w(5);
      scl = 1'b1; w(10);
      scl = 1'b0; w(5);
   endtask

   task automatic push_wr(input logic [12:0] a, input logic [7:0] d, input string tag);
      wr_item_t it;
      it.a = a; it.d = d; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic do_read(input logic [12:0] exp_ptr, input string tag);
      logic ack;
      logic [7:0] b;
      h_start();
      h_send(8'hAB, ack);
      chk({tag, " read device ack (R4)"}, ack, 1'b1);
      h_recv(b);
      h_stop();
      chk({tag, " read byte"}, b, mem_val(exp_ptr));
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R3 unexpected write actual=%0h:%0h expected=none", wr_addr, wr_data);
            end else begin
               wr_item_t it;
               it = exp_q.pop_front();
               chk({it.tag, " wr_addr"}, wr_addr, it.a);
               chk({it.tag, " wr_data"}, wr_data, it.d);
            end
         end
         if (wr_commit) got_commits++;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic ack;
      w(5);
      chk("R11 reset sda_oe", sda_oe, 1'b0);
      chk("R6 reset wr_valid", wr_valid, 1'b0);
      chk("R8 reset wr_commit", wr_commit, 1'b0);
      rst_n = 1'b1;
      w(10);

      // R2 R5 R6 R7 R8: write four bytes across the page boundary at 0x1ADE
      h_start();
      h_send(8'hAA, ack); chk("R2 device match ack", ack, 1'b1);
      h_send(8'hFA, ack); chk("R5 high address ack", ack, 1'b1);
      h_send(8'hDE, ack); chk("R5 low address ack", ack, 1'b1);
      push_wr(13'h1ADE, 8'h11, "R6");
      push_wr(13'h1ADF, 8'h22, "R6");
      push_wr(13'h1AC0, 8'h33, "R7 wrap");
      push_wr(13'h1AC1, 8'h44, "R7");
      h_send(8'h11, ack); chk("R6 data ack", ack, 1'b1);
      h_send(8'h22, ack); chk("R6 data ack", ack, 1'b1);
      h_send(8'h33, ack); chk("R6 data ack", ack, 1'b1);
      h_send(8'h44, ack); chk("R6 data ack", ack, 1'b1);
      h_stop();
      exp_commits++;
      w(10);
      chk("R8 commit after data", got_commits, exp_commits);
      chk("R11 released when idle", sda_oe, 1'b0);

      // R9 R3: polling while busy
      busy = 1'b1;
      h_start();
      h_send(8'hAA, ack); chk("R9 no ack while busy", ack, 1'b0);
      h_send(8'h00, ack); chk("R3 ignored after nack", ack, 1'b0);
      h_send(8'h05, ack); chk("R3 ignored after nack", ack, 1'b0);
      h_stop();
      busy = 1'b0;
      h_start();
      h_send(8'hAA, ack); chk("R9 ack after busy drops", ack, 1'b1);
      h_stop();
      w(10);
      chk("R8 no commit without data", got_commits, exp_commits);

      // R10 R4: current-address reads continue after the last written byte
      do_read(13'h1AC2, "R10");
      do_read(13'h1AC3, "R10");

      // R2 R3: wrong strap and wrong code
      h_start();
      h_send(8'hA0, ack); chk("R2 strap mismatch nack", ack, 1'b0);
      h_send(8'h00, ack); chk("R3 no ack after mismatch", ack, 1'b0);
      h_send(8'h55, ack); chk("R3 no ack after mismatch", ack, 1'b0);
      h_stop();
      h_start();
      h_send(8'hBA, ack); chk("R2 code mismatch nack", ack, 1'b0);
      h_stop();
      w(10);
      chk("R3 no commit after mismatch", got_commits, exp_commits);

      // R8 R10: dummy write to 0x1FFF then full-width pointer rollover
      h_start();
      h_send(8'hAA, ack); chk("R2 ack", ack, 1'b1);
      h_send(8'hFF, ack); chk("R5 ack, upper bits ignored", ack, 1'b1);
      h_send(8'hFF, ack); chk("R5 ack", ack, 1'b1);
      h_stop();
      w(10);
      chk("R8 address-only write no commit", got_commits, exp_commits);
      do_read(13'h1FFF, "R10");
      do_read(13'h0000, "R10 rollover");

      // R12 R1: START in the middle of a data byte
      h_start();
      h_send(8'hAA, ack); chk("R2 ack", ack, 1'b1);
      h_send(8'h00, ack); chk("R5 ack", ack, 1'b1);
      h_send(8'h40, ack); chk("R5 ack", ack, 1'b1);
      push_wr(13'h0040, 8'h77, "R6");
      h_send(8'h77, ack); chk("R6 data ack", ack, 1'b1);
      h_bits(8'h99, 4);
      h_start();
      h_send(8'hA0, ack); chk("R1 restart then mismatch nack", ack, 1'b0);
      h_stop();
      w(10);
      chk("R12 no commit after abort", got_commits, exp_commits);
      do_read(13'h0041, "R1 after restart");

      w(20);
      chk("R6 all writes seen", exp_q.size(), 0);
      chk("R8 commit count", got_commits, exp_commits);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule